// File: doc/BRIEF.md
# Draw Command Fetch with Clip Rejection

This block sits at the front of a sprite blitter. Software writes a list of fixed-size draw commands into main memory. It then gives the block a base address and a command count and pulses `start`. The block reads the list in fixed-size bursts and pushes each returned word into a word FIFO. It rebuilds five-word commands from the FIFO. A command can be split across two bursts, because a 64-byte burst does not hold a whole number of 20-byte commands.

Each rebuilt command is tested against an inclusive clip rectangle. When clipping is on and the destination rectangle misses the window entirely, the command is dropped, so no pixel copy is ever issued for it. Any command that touches the window, even by a single pixel, is passed downstream unchanged, so its pixels outside the window are still written. Downstream takes commands through a valid/ready handshake.

While a list is in flight, a counter records every cycle in which no accepted command is being offered. A run of rejected draws therefore shows up as busy-but-idle time.

Top module: `blit_cmd_fetch`

## Requirements
- R1: After reset `busy`, `cmdValid` and `memReq` are low and `idleCount` is zero.
- R2: A `start` with N commands issues exactly ceil(5N/16) burst requests. Their addresses are `baseAddr`, `baseAddr`+64, `baseAddr`+128 and so on. Each granted burst returns 16 words, and word k of a burst comes from byte address burst+4k. Words beyond the 5N list words are discarded.
- R3: Accepted commands leave in list order. `cmdData` holds list word j of the command at bits [32j+31:32j], for j = 0..4. Word 0 is {srcY, srcX}, word 1 is {dstY, dstX} and word 2 is {sizeY, sizeX}, each with the X half in the low 16 bits. Words 3 and 4 pass through unchanged.
- R4: With `clipEn` high, a command is dropped exactly when dstX+sizeX-1 < `clipMinX`, or dstX > `clipMaxX`, or dstY+sizeY-1 < `clipMinY`, or dstY > `clipMaxY`. All bounds are inclusive and the arithmetic does not wrap.
- R5: A command that overlaps the window only partly is emitted with all five words unmodified.
- R6: With `clipEn` low, every command in the list is emitted.
- R7: While `cmdValid` is high and `cmdReady` is low, `cmdValid` stays high and `cmdData` holds its value.
- R8: `idleCount` is cleared by an accepted `start`. It then grows by one for every cycle in which `busy` is high and `cmdValid` is low. It does not change while `busy` is low.
- R9: `busy` falls once every burst has returned and every command has been either dropped or taken. A `start` while `busy` is high has no effect on addresses, on the count or on the output stream.
- R10: A burst request that is not granted stays asserted on the next cycle with the same `memAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin fetching a list (ignored while busy) |
| baseAddr | input | ADDR_W | Byte address of the first command |
| numCmds | input | CNT_W | Number of commands in the list |
| clipEn | input | 1 | Enables clip rejection |
| clipMinX | input | COORD_W | Left edge of window, inclusive |
| clipMaxX | input | COORD_W | Right edge of window, inclusive |
| clipMinY | input | COORD_W | Top edge of window, inclusive |
| clipMaxY | input | COORD_W | Bottom edge of window, inclusive |
| memReq | output | 1 | Burst read request |
| memAddr | output | ADDR_W | Byte address of the requested burst |
| memGnt | input | 1 | Request accepted this cycle |
| memRdValid | input | 1 | One returned word is present |
| memRdData | input | 32 | Returned word |
| cmdValid | output | 1 | An accepted command is offered |
| cmdReady | input | 1 | Downstream takes the offered command |
| cmdData | output | 160 | Offered command, five words |
| busy | output | 1 | A list is in progress |
| idleCount | output | IDLE_W | Cycles busy without an offered command |

## Verification
The checker takes for granted that the clip window and `clipEn` stay constant from an accepted `start` until `busy` falls. It also assumes the memory returns exactly sixteen words for each granted burst, and never words that were not requested. The bench memory model only returns words for bursts it has already granted, and it changes the window only between runs. Stalls on the grant, gaps between returned words and random backpressure on `cmdReady` are all produced inside those limits.

// File: rtl/blit_fetch_pkg.sv
package blit_fetch_pkg;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = 8 * WORD_BYTES;
  localparam int COORD_W    = WORD_W / 2;
  localparam int CMD_BYTES  = 20;
  localparam int CMD_WORDS  = CMD_BYTES / WORD_BYTES;
  localparam int IDX_W      = $clog2(CMD_WORDS + 1);
  localparam int CMD_W      = CMD_WORDS * WORD_W;

  // word positions inside a command that the clip test decodes
  localparam int DST_WORD  = 1;
  localparam int SIZE_WORD = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic             push;   // store returned word in FIFO
    logic             pop;    // move FIFO head into assembly slot
    logic [IDX_W-1:0] slot;   // slot written by pop
    logic             load;   // copy assembled command to output
    logic             take;   // downstream consumed output
  } dp_ctl_t;
endpackage

// File: rtl/blit_fetch_dp.sv
module blit_fetch_dp
  import blit_fetch_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1),
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  dp_ctl_t            ctl,
  input  logic [WORD_W-1:0]  rdData,
  input  logic               clipEn,
  input  logic [COORD_W-1:0] clipMinX,
  input  logic [COORD_W-1:0] clipMaxX,
  input  logic [COORD_W-1:0] clipMinY,
  input  logic [COORD_W-1:0] clipMaxY,
  output logic [LVL_W-1:0]   level,
  output logic               visible,
  output logic               cmdValid,
  output logic [CMD_W-1:0]   cmdData
);
  // ---------------- word FIFO ----------------
  logic [WORD_W-1:0] store [FIFO_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [WORD_W-1:0] head;

  function automatic logic [PTR_W-1:0] ptrNext(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (ctl.push) store[wrPtr] <= rdData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (ctl.push) wrPtr <= ptrNext(wrPtr);
      if (ctl.pop)  rdPtr <= ptrNext(rdPtr);
      case ({ctl.push, ctl.pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign head = store[rdPtr];

  // ---------------- command assembly ----------------
  logic [CMD_W-1:0] asmVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      asmVec <= '0;
    end else begin
      for (int s = 0; s < CMD_WORDS; s++) begin
        if (ctl.pop && ctl.slot == IDX_W'(s))
          asmVec[s*WORD_W +: WORD_W] <= head;
      end
    end
  end

  // ---------------- clip test, one instance per axis ----------------
  logic [COORD_W-1:0] lo [2];
  logic [COORD_W-1:0] hi [2];
  logic [1:0]         outside;

  assign lo[0] = clipMinX;
  assign hi[0] = clipMaxX;
  assign lo[1] = clipMinY;
  assign hi[1] = clipMaxY;

  for (genvar ax = 0; ax < 2; ax++) begin : g_axis
    localparam int POS_LSB = DST_WORD * WORD_W + ax * COORD_W;
    localparam int LEN_LSB = SIZE_WORD * WORD_W + ax * COORD_W;
    logic [COORD_W-1:0] pos, len;
    logic [COORD_W:0]   pastEnd;   // first coordinate beyond the draw
    assign pos     = asmVec[POS_LSB +: COORD_W];
    assign len     = asmVec[LEN_LSB +: COORD_W];
    assign pastEnd = {1'b0, pos} + {1'b0, len};
    assign outside[ax] = (pastEnd <= {1'b0, lo[ax]}) || (pos > hi[ax]);
  end

  assign visible = !clipEn || (outside == 2'b00);

  // ---------------- output register ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      cmdData  <= '0;
    end else begin
      if (ctl.load) begin
        cmdValid <= 1'b1;
        cmdData  <= asmVec;
      end else if (ctl.take) begin
        cmdValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/blit_fetch_ctl.sv
module blit_fetch_ctl
  import blit_fetch_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 10,
  parameter int IDLE_W      = 32,
  parameter int BURST_BYTES = 64,
  parameter int FIFO_DEPTH  = 32,
  localparam int LVL_W  = $clog2(FIFO_DEPTH + 1),
  localparam int BW     = BURST_BYTES / WORD_BYTES,
  localparam int KEEP_W = CNT_W + 3,
  localparam int OUT_W  = $clog2(FIFO_DEPTH + BW + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [CNT_W-1:0]  numCmds,
  input  logic              memGnt,
  input  logic              memRdValid,
  input  logic              cmdReady,
  input  logic [LVL_W-1:0]  level,
  input  logic              visible,
  input  logic              cmdValid,
  output dp_ctl_t           ctl,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic              busy,
  output logic [IDLE_W-1:0] idleCount
);
  logic [KEEP_W-1:0] keepLeft, burstsLeft;
  logic [KEEP_W-1:0] listWords, listBursts;
  logic [OUT_W-1:0]  outstanding;
  logic [ADDR_W-1:0] nextAddr;
  logic [IDX_W-1:0]  asmCnt;

  logic startOk, room, grant, push, pop, asmFull, take, load, drop;

  assign listWords  = KEEP_W'(numCmds) * KEEP_W'(CMD_WORDS);
  assign listBursts = KEEP_W'((32'(listWords) + BW - 1) / BW);

  assign busy = (burstsLeft != '0) || (outstanding != '0) || (level != '0)
             || (asmCnt != '0) || cmdValid;

  assign startOk = start && !busy;

  // request a burst only while the FIFO can hold every word in flight
  assign room    = (32'(level) + 32'(outstanding) + BW) <= FIFO_DEPTH;
  assign memReq  = (burstsLeft != '0) && room;
  assign memAddr = nextAddr;
  assign grant   = memReq && memGnt;

  assign push    = memRdValid && (keepLeft != '0);
  assign asmFull = (asmCnt == IDX_W'(CMD_WORDS));
  assign pop     = (level != '0) && !asmFull;
  assign take    = cmdValid && cmdReady;
  assign load    = asmFull && visible && (!cmdValid || cmdReady);
  assign drop    = asmFull && !visible;

  always_comb begin
    ctl.push = push;
    ctl.pop  = pop;
    ctl.slot = asmCnt;
    ctl.load = load;
    ctl.take = take;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keepLeft    <= '0;
      burstsLeft  <= '0;
      outstanding <= '0;
      nextAddr    <= '0;
      asmCnt      <= '0;
      idleCount   <= '0;
    end else begin
      if (startOk) begin
        nextAddr   <= baseAddr;
        keepLeft   <= listWords;
        burstsLeft <= listBursts;
      end else begin
        if (grant) begin
          nextAddr   <= nextAddr + ADDR_W'(BURST_BYTES);
          burstsLeft <= burstsLeft - 1'b1;
        end
        if (push) keepLeft <= keepLeft - 1'b1;
      end

      outstanding <= outstanding + (grant ? OUT_W'(BW) : OUT_W'(0))
                                 - (memRdValid ? OUT_W'(1) : OUT_W'(0));

      if (load || drop)   asmCnt <= '0;
      else if (pop)       asmCnt <= asmCnt + 1'b1;

      if (startOk)                idleCount <= '0;
      else if (busy && !cmdValid) idleCount <= idleCount + 1'b1;
    end
  end
endmodule

// File: rtl/blit_cmd_fetch.sv
module blit_cmd_fetch
  import blit_fetch_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 10,
  parameter int IDLE_W      = 32,
  parameter int BURST_BYTES = 64,
  parameter int FIFO_DEPTH  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [ADDR_W-1:0]  baseAddr,
  input  logic [CNT_W-1:0]   numCmds,
  input  logic               clipEn,
  input  logic [COORD_W-1:0] clipMinX,
  input  logic [COORD_W-1:0] clipMaxX,
  input  logic [COORD_W-1:0] clipMinY,
  input  logic [COORD_W-1:0] clipMaxY,
  output logic               memReq,
  output logic [ADDR_W-1:0]  memAddr,
  input  logic               memGnt,
  input  logic               memRdValid,
  input  logic [WORD_W-1:0]  memRdData,
  output logic               cmdValid,
  input  logic               cmdReady,
  output logic [CMD_W-1:0]   cmdData,
  output logic               busy,
  output logic [IDLE_W-1:0]  idleCount
);
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  dp_ctl_t          ctl;
  logic [LVL_W-1:0] level;
  logic             visible;

  blit_fetch_ctl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDLE_W(IDLE_W),
    .BURST_BYTES(BURST_BYTES), .FIFO_DEPTH(FIFO_DEPTH)
  ) ctl_i (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr),
    .numCmds(numCmds), .memGnt(memGnt), .memRdValid(memRdValid),
    .cmdReady(cmdReady), .level(level), .visible(visible),
    .cmdValid(cmdValid), .ctl(ctl), .memReq(memReq), .memAddr(memAddr),
    .busy(busy), .idleCount(idleCount)
  );

  blit_fetch_dp #(.FIFO_DEPTH(FIFO_DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rdData(memRdData),
    .clipEn(clipEn), .clipMinX(clipMinX), .clipMaxX(clipMaxX),
    .clipMinY(clipMinY), .clipMaxY(clipMaxY), .level(level),
    .visible(visible), .cmdValid(cmdValid), .cmdData(cmdData)
  );
endmodule

// File: rtl/blit_fetch_chk.sv
module blit_fetch_chk
  import blit_fetch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDLE_W = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               clipEn,
  input logic [COORD_W-1:0] clipMinX,
  input logic [COORD_W-1:0] clipMaxX,
  input logic [COORD_W-1:0] clipMinY,
  input logic [COORD_W-1:0] clipMaxY,
  input logic               memReq,
  input logic               memGnt,
  input logic [ADDR_W-1:0]  memAddr,
  input logic               cmdValid,
  input logic               cmdReady,
  input logic [CMD_W-1:0]   cmdData,
  input logic               busy,
  input logic [IDLE_W-1:0]  idleCount
);
  int dX, dY, wX, wY;
  logic missWin;
  always_comb begin
    dX = int'(cmdData[DST_WORD*WORD_W +: COORD_W]);
    dY = int'(cmdData[DST_WORD*WORD_W + COORD_W +: COORD_W]);
    wX = int'(cmdData[SIZE_WORD*WORD_W +: COORD_W]);
    wY = int'(cmdData[SIZE_WORD*WORD_W + COORD_W +: COORD_W]);
    missWin = (dX + wX - 1 < int'(clipMinX)) || (dX > int'(clipMaxX))
           || (dY + wY - 1 < int'(clipMinY)) || (dY > int'(clipMaxY));
  end

  // offered commands always touch the window when clipping is on
  p_visible_out_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && clipEn |-> !missWin);

  p_hold_out_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdData));

  p_idle_grow_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy && !cmdValid |=> idleCount == $past(idleCount) + IDLE_W'(1));

  p_idle_freeze_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !start |=> $stable(idleCount));

  p_idle_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busy && start |=> idleCount == '0);

  p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq && !cmdValid);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGnt |=> memReq && $stable(memAddr));
endmodule

bind blit_cmd_fetch blit_fetch_chk #(.ADDR_W(ADDR_W), .IDLE_W(IDLE_W)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .clipEn(clipEn),
  .clipMinX(clipMinX), .clipMaxX(clipMaxX), .clipMinY(clipMinY),
  .clipMaxY(clipMaxY), .memReq(memReq), .memGnt(memGnt), .memAddr(memAddr),
  .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdData(cmdData),
  .busy(busy), .idleCount(idleCount)
);

// File: tb/blit_cmd_fetch_tb_top.sv
module blit_cmd_fetch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 10;
  localparam int IDLE_W = 32;
  localparam int BW     = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [31:0]  baseAddr = '0;
  logic [9:0]   numCmds = '0;
  logic         clipEn = 1'b0;
  logic [15:0]  clipMinX = '0, clipMaxX = '0, clipMinY = '0, clipMaxY = '0;
  logic         memReq;
  logic [31:0]  memAddr;
  logic         memGnt = 1'b0;
  logic         memRdValid = 1'b0;
  logic [31:0]  memRdData = '0;
  logic         cmdValid;
  logic         cmdReady = 1'b0;
  logic [159:0] cmdData;
  logic         busy;
  logic [31:0]  idleCount;

  blit_cmd_fetch #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDLE_W(IDLE_W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr),
    .numCmds(numCmds), .clipEn(clipEn), .clipMinX(clipMinX),
    .clipMaxX(clipMaxX), .clipMinY(clipMinY), .clipMaxY(clipMaxY),
    .memReq(memReq), .memAddr(memAddr), .memGnt(memGnt),
    .memRdValid(memRdValid), .memRdData(memRdData), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .cmdData(cmdData), .busy(busy),
    .idleCount(idleCount)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] memW [1024];
  int nCmd = 0, expN = 0, gotN = 0;
  int expOrder [256];
  int burstsSeen = 0, benchIdle = 0;
  logic [31:0] qAddr [16];
  int qWr = 0, qRd = 0, beat = 0;
  bit readyMode = 0, stallMode = 0, monOn = 0;
  logic [31:0] runBase = 32'h0001_0000;
  logic [15:0] lfsr = 16'hACE1;
  string curTag = "R3";
  bit cEn = 0;
  int cMinX = 0, cMaxX = 0, cMinY = 0, cMaxY = 0;
  bit prevHeld = 0, prevReqWait = 0;
  logic [159:0] prevData = '0;
  logic [31:0] prevAddr = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  function automatic logic [159:0] cmdVec(input int k);
    return {memW[k*5+4], memW[k*5+3], memW[k*5+2], memW[k*5+1], memW[k*5]};
  endfunction

  function automatic logic [31:0] memWord(input logic [31:0] a);
    int off;
    off = int'((a - runBase) >> 2);
    if (off >= 0 && off < nCmd * 5) return memW[off];
    return 32'hBAD0_0000 | 32'(off);
  endfunction

  task automatic setClip(input bit en, input int mnx, input int mxx,
                         input int mny, input int mxy);
    cEn = en; cMinX = mnx; cMaxX = mxx; cMinY = mny; cMaxY = mxy;
    clipEn = en;
    clipMinX = 16'(mnx); clipMaxX = 16'(mxx);
    clipMinY = 16'(mny); clipMaxY = 16'(mxy);
    nCmd = 0; expN = 0;
  endtask

  // R4 rule computed arithmetically, independent of the design
  task automatic addCmd(input int sx, input int sy, input int dx, input int dy,
                        input int w, input int h);
    int b;
    bit miss;
    b = nCmd * 5;
    memW[b]   = {sy[15:0], sx[15:0]};
    memW[b+1] = {dy[15:0], dx[15:0]};
    memW[b+2] = {h[15:0], w[15:0]};
    memW[b+3] = 32'hC0DE_0000 | 32'(nCmd);
    memW[b+4] = ~(32'h5A00_0000 | 32'(nCmd * 7));
    miss = (dx + w - 1 < cMinX) || (dx > cMaxX) || (dy + h - 1 < cMinY) || (dy > cMaxY);
    if (!cEn || !miss) begin
      expOrder[expN] = nCmd;
      expN++;
    end
    nCmd++;
  endtask

  // memory model, downstream sink and port monitor
  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (monOn) begin
        if (busy && !cmdValid) benchIdle++;
        // returned words, only for bursts granted earlier
        if (qRd != qWr && (!stallMode || lfsr[3])) begin
          memRdValid = 1'b1;
          memRdData  = memWord(qAddr[qRd % 16] + 32'(4 * beat));
          beat++;
          if (beat == BW) begin beat = 0; qRd++; end
        end else begin
          memRdValid = 1'b0;
        end
        // R7: offered command held under backpressure
        if (prevHeld)
          chk(cmdValid && cmdData == prevData, "R7", "held command", cmdData, prevData);
        cmdReady = readyMode ? (lfsr[0] | lfsr[5]) : 1'b1;
        if (cmdValid && cmdReady) begin
          if (gotN < expN)
            chk(cmdData == cmdVec(expOrder[gotN]), curTag, "emitted command",
                cmdData, cmdVec(expOrder[gotN]));
          else
            chk(1'b0, curTag, "extra command", cmdData, '0);
          gotN++;
        end
        prevHeld = cmdValid && !cmdReady;
        prevData = cmdData;
        // R10: ungranted request held with same address
        if (prevReqWait)
          chk(memReq && memAddr == prevAddr, "R10", "request hold",
              {memReq, memAddr}, {1'b1, prevAddr});
        memGnt = stallMode ? lfsr[2] : 1'b1;
        if (memReq && memGnt) begin
          chk(memAddr == runBase + 32'(64 * burstsSeen), "R2", "burst address",
              memAddr, runBase + 32'(64 * burstsSeen));
          qAddr[qWr % 16] = memAddr;
          qWr++;
          burstsSeen++;
        end
        prevReqWait = memReq && !memGnt;
        prevAddr = memAddr;
      end
    end
  end

  task automatic runList(input string tag, input bit rMode, input bit sMode,
                         input bit restart, input logic [31:0] base);
    curTag = tag; readyMode = rMode; stallMode = sMode;
    gotN = 0; burstsSeen = 0; benchIdle = 0; qWr = 0; qRd = 0; beat = 0;
    prevHeld = 0; prevReqWait = 0;
    runBase = base; baseAddr = base; numCmds = 10'(nCmd);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (restart) begin
      repeat (15) @(negedge clk);
      baseAddr = 32'h0009_0000; numCmds = 10'd3; start = 1'b1;
      @(negedge clk);
      start = 1'b0; baseAddr = base;
    end
    while (busy) @(negedge clk);
    chk(gotN == expN, tag, "command count", 160'(gotN), 160'(expN));
    chk(burstsSeen == (nCmd * 5 + BW - 1) / BW, "R2", "burst count",
        160'(burstsSeen), 160'((nCmd * 5 + BW - 1) / BW));
    chk(idleCount == 32'(benchIdle), "R8", "idle cycles", 160'(idleCount), 160'(benchIdle));
    chk(!memReq && !cmdValid && qRd == qWr, "R9", "quiet after busy",
        {memReq, cmdValid}, 160'(0));
    repeat (3) @(negedge clk);
    chk(idleCount == 32'(benchIdle), "R8", "idle frozen", 160'(idleCount), 160'(benchIdle));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R9", "watchdog expired", '0, '0);
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy, "R1", "busy after reset", 160'(busy), 160'(0));
    chk(!cmdValid, "R1", "cmdValid after reset", 160'(cmdValid), 160'(0));
    chk(!memReq, "R1", "memReq after reset", 160'(memReq), 160'(0));
    chk(idleCount == 0, "R1", "idleCount after reset", 160'(idleCount), 160'(0));
    monOn = 1;

    // R4 sweep along X across both window edges
    setClip(1, 20, 40, 10, 30);
    for (int dx = 14; dx <= 46; dx++)
      for (int k = 0; k < 3; k++) addCmd(dx * 3, k, dx, 12, (k == 0) ? 1 : (k == 1) ? 3 : 6, 2);
    runList("R4", 0, 0, 0, 32'h0001_0000);

    // R4 sweep along Y
    setClip(1, 20, 40, 10, 30);
    for (int dy = 4; dy <= 36; dy++)
      for (int k = 0; k < 3; k++) addCmd(k, dy, 25, dy, 2, (k == 0) ? 1 : (k == 1) ? 3 : 6);
    runList("R4", 0, 0, 0, 32'h0002_0040);

    // R6: clip disabled, same geometry
    setClip(0, 20, 40, 10, 30);
    for (int dx = 14; dx <= 46; dx++) addCmd(dx, 1, dx, 40, 2, 2);
    runList("R6", 0, 0, 0, 32'h0003_0000);

    // R5: partial overlaps pass unmodified, total misses dropped
    setClip(1, 416, 735, 128, 368);
    addCmd(864, 128, 414, 128, 324, 1);
    addCmd(10, 20, 100, 200, 300, 4);
    addCmd(11, 21, 736, 200, 8, 8);
    addCmd(12, 22, 500, 369, 8, 8);
    addCmd(13, 23, 500, 127, 8, 1);
    addCmd(14, 24, 500, 127, 8, 2);
    addCmd(15, 25, 700, 360, 100, 100);
    runList("R5", 0, 0, 0, 32'h0004_0000);

    // R8: every draw rejected, engine busy but never offering
    setClip(1, 416, 735, 128, 368);
    for (int i = 0; i < 16; i++) addCmd(i, i, 90 + i, 200, 4, 1);
    runList("R8", 0, 0, 0, 32'h0005_0000);

    // R7: backpressure and memory stalls with mixed accept/reject
    setClip(1, 20, 40, 10, 30);
    for (int dx = 16; dx <= 44; dx++) addCmd(dx, 2, dx, 8 + (dx % 5), 3, 2);
    runList("R7", 1, 1, 0, 32'h0006_0000);

    // R9: start while busy is ignored
    setClip(1, 20, 40, 10, 30);
    for (int dx = 18; dx <= 42; dx++) addCmd(dx, 3, dx, 20, 2, 2);
    runList("R9", 1, 1, 1, 32'h0007_0000);

    finishRun();
  end
endmodule